// File: doc/BRIEF.md
# Dual-Edge One-or-One-and-a-Half Clock Divider Cell

This cell divides a clock either by one or by one and a half. The clock being divided is modelled at the cycle level. Each cycle of the block clock `clk` stands for one half-period of that divided clock, and the level of the divided clock in that half-period arrives on `in_lvl`.

Two storage paths run side by side:
- The positive path updates only in half-periods where `in_lvl` is high.
- The negative path updates only in half-periods where `in_lvl` is low.

A selector picks the path that matches the current phase to drive the output. Because of this, output edges can land on either edge of the divided clock, and so a half-integer ratio is possible.

The cell divides by one and a half only when both `mod_in` and `fb_in` are high. `mod_in` is the local modulus request and `fb_in` is the enable fed back from the next stage. In that mode, `div_out` produces one period every three half-periods. `mod_out` pulses once per output period so that a following divider chain can request the extra half cycle. When either control is low, the output follows the input clock and the ratio is one.

Top module: `half_step_divider`

## Requirements
- R1: When `mod_in` and `fb_in` are both high, successive rising edges of `div_out` are exactly 3 half-periods (3 `clk` cycles) apart.
- R2: When `mod_in` or `fb_in` is low, `div_out` after each `clk` edge equals the `in_lvl` sampled at that edge, giving rising edges 2 half-periods apart.
- R3: In divide-by-1.5 mode, `div_out` is high in exactly one of every three consecutive half-periods.
- R4: In divide-by-1.5 mode, consecutive rising edges of `div_out` alternate between the positive path and the negative path. A rise belongs to the positive path when `in_lvl` at that edge is 1, and to the negative path when it is 0.
- R5: `mod_out` is high exactly in the half-periods where `div_out` is high while divide-by-1.5 is active, and it stays low in divide-by-1 mode.
- R6: Synchronous active-high `rst` clears both paths, the phase counter and the mode, so the edge after reset shows `div_out`=0 and `mod_out`=0, and the cell restarts in divide-by-1 mode.
- R7: The mode follows the control inputs sampled on every `clk` edge. Dropping either control returns the cell to 2-half-period output periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, one cycle per half-period of the divided clock |
| rst | input | 1 | Synchronous active-high reset |
| in_lvl | input | 1 | Level of the clock being divided during this half-period |
| mod_in | input | 1 | Modulus request for the extra half cycle |
| fb_in | input | 1 | Feedback enable from the following stage |
| div_out | output | 1 | Divided clock level |
| mod_out | output | 1 | Modulus output to the next stage, one pulse per output period in divide-by-1.5 |

## Verification
The bench drives all four combinations of the two control bits, because a cell that decodes OR instead of AND would produce 3-half-period periods where the bench expects 2. In divide-by-1.5 mode it checks the edge alternation. A cell that used only one path would slip to 4-half-period spacing, and the bench would see two consecutive rises on the same path. It also returns the cell to divide-by-1 after a divide-by-1.5 run, and applies reset in the middle of that mode. A sticky mode register or an uncleared path would then leave stale highs on `div_out` or `mod_out`.

// File: rtl/half_step_pkg.sv
package half_step_pkg;

    // Half-periods per output period in each mode
    localparam int unsigned FRAC_SPAN  = 3;
    localparam int unsigned WHOLE_SPAN = 2;
    localparam int unsigned PH_W       = $clog2(FRAC_SPAN);

    typedef logic [PH_W-1:0] phase_t;

    typedef enum logic {
        MODE_WHOLE = 1'b0,
        MODE_FRAC  = 1'b1
    } div_mode_e;

    typedef struct packed {
        logic pos_lvl;
        logic neg_lvl;
        logic sel_pos;
    } path_state_t;

    typedef struct packed {
        logic lvl;
        logic mod;
    } cell_next_t;

    function automatic phase_t phase_step(input phase_t ph);
        return (ph == phase_t'(FRAC_SPAN - 1)) ? '0 : ph + phase_t'(1);
    endfunction

    function automatic cell_next_t next_levels(input div_mode_e md,
                                               input phase_t    ph,
                                               input logic      lvl_in);
        cell_next_t r;
        if (md == MODE_FRAC) begin
            r.lvl = (ph == '0);
            r.mod = (ph == '0);
        end else begin
            r.lvl = lvl_in;
            r.mod = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/half_step_ctrl.sv
module half_step_ctrl
    import half_step_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mod_in,
    input  logic      fb_in,
    output div_mode_e mode_q,
    output phase_t    phase_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= MODE_WHOLE;
            phase_q <= '0;
        end else begin
            mode_q  <= (mod_in && fb_in) ? MODE_FRAC : MODE_WHOLE;
            if (mode_q == MODE_FRAC)
                phase_q <= phase_step(phase_q);
            else
                phase_q <= '0;
        end
    end

endmodule

// File: rtl/half_step_paths.sv
module half_step_paths
    import half_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_lvl,
    input  cell_next_t nxt,
    output logic       lvl_out,
    output logic       mod_out
);

    path_state_t st_q;
    logic        pos_mod_q;
    logic        neg_mod_q;

    // Positive-phase path: captures only in high half-periods
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pos_lvl <= 1'b0;
            pos_mod_q    <= 1'b0;
        end else if (in_lvl) begin
            st_q.pos_lvl <= nxt.lvl;
            pos_mod_q    <= nxt.mod;
        end
    end

    // Negative-phase path: captures only in low half-periods
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.neg_lvl <= 1'b0;
            neg_mod_q    <= 1'b0;
        end else if (!in_lvl) begin
            st_q.neg_lvl <= nxt.lvl;
            neg_mod_q    <= nxt.mod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q.sel_pos <= 1'b0;
        else     st_q.sel_pos <= in_lvl;
    end

    always_comb begin
        lvl_out = st_q.sel_pos ? st_q.pos_lvl : st_q.neg_lvl;
        mod_out = st_q.sel_pos ? pos_mod_q    : neg_mod_q;
    end

endmodule

// File: rtl/half_step_divider.sv
module half_step_divider
    import half_step_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_lvl,
    input  logic mod_in,
    input  logic fb_in,
    output logic div_out,
    output logic mod_out
);

    div_mode_e  mode_q;
    phase_t     phase_q;
    cell_next_t nxt;
    logic       frac_q;

    half_step_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .mod_in  (mod_in),
        .fb_in   (fb_in),
        .mode_q  (mode_q),
        .phase_q (phase_q)
    );

    always_comb begin
        nxt    = next_levels(mode_q, phase_q, in_lvl);
        frac_q = (mode_q == MODE_FRAC);
    end

    half_step_paths u_paths (
        .clk     (clk),
        .rst     (rst),
        .in_lvl  (in_lvl),
        .nxt     (nxt),
        .lvl_out (div_out),
        .mod_out (mod_out)
    );

endmodule

// File: rtl/half_step_divider_chk.sv
module half_step_divider_chk (
    input logic clk,
    input logic rst,
    input logic in_lvl,
    input logic frac_q,
    input logic div_out,
    input logic mod_out
);

    logic [2:0] alive_q;

    always_ff @(posedge clk) begin
        if (rst)                alive_q <= '0;
        else if (alive_q != 3'd4) alive_q <= alive_q + 3'd1;
    end

    // R2: divide-by-1 output tracks the sampled input level
    assert_whole_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (alive_q != 3'd0 && !$past(frac_q)) |-> (div_out == $past(in_lvl)));

    // R3: one high half-period in every three in divide-by-1.5
    assert_one_in_three_R3: assert property (@(posedge clk) disable iff (rst)
        (alive_q == 3'd4 && $past(frac_q) && $past(frac_q, 2) && $past(frac_q, 3))
        |-> ($countones({div_out, $past(div_out), $past(div_out, 2)}) == 1));

    // R5: modulus pulse only coincides with a high output
    assert_mod_with_out_R5: assert property (@(posedge clk) disable iff (rst)
        mod_out |-> div_out);

    // R5: no modulus pulse in divide-by-1
    assert_mod_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (alive_q != 3'd0 && !$past(frac_q)) |-> !mod_out);

    // R6: reset clears both outputs
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (!div_out && !mod_out));

endmodule

bind half_step_divider half_step_divider_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .in_lvl  (in_lvl),
    .frac_q  (frac_q),
    .div_out (div_out),
    .mod_out (mod_out)
);

// File: tb/half_step_divider_test.sv
module half_step_divider_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_lvl = 1'b0;
    logic mod_in = 1'b0;
    logic fb_in = 1'b0;
    logic div_out;
    logic mod_out;

    int n_chk = 0;
    int n_bad = 0;
    int exp_q[$];
    logic measure = 1'b0;
    logic frac_exp = 1'b0;
    logic have_last = 1'b0;
    int   hc = 0;
    int   last_hc = 0;
    logic last_path = 1'b0;
    logic prev_div = 1'b0;

    half_step_divider uut (
        .clk     (clk),
        .rst     (rst),
        .in_lvl  (in_lvl),
        .mod_in  (mod_in),
        .fb_in   (fb_in),
        .div_out (div_out),
        .mod_out (mod_out)
    );

    always #5 clk = ~clk;

    always @(negedge clk) in_lvl <= ~in_lvl;

    task automatic check(input string req, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Monitor: pops expected periods and compares as rises appear
    always @(posedge clk) begin
        #1;
        hc++;
        if (measure) begin
            if (!frac_exp) check("R2 follow", int'(div_out), int'(in_lvl));
            if (div_out && !prev_div) begin
                check("R5 mod at rise", int'(mod_out), int'(frac_exp));
                if (have_last) begin
                    if (exp_q.size() > 0) begin
                        int e;
                        e = exp_q.pop_front();
                        check(frac_exp ? "R1 period" : "R7 period", hc - last_hc, e);
                    end
                    if (frac_exp)
                        check("R4 path alternation", int'(in_lvl), int'(!last_path));
                end
                have_last = 1'b1;
                last_hc   = hc;
                last_path = in_lvl;
            end
            if (!div_out) check("R5 mod low", int'(mod_out), 0);
        end
        prev_div = div_out;
    end

    task automatic run_mode(input logic m, input logic f, input int n);
        @(negedge clk);
        mod_in = m;
        fb_in  = f;
        repeat (8) @(negedge clk);
        frac_exp  = m && f;
        have_last = 1'b0;
        for (int i = 0; i < n; i++) exp_q.push_back((m && f) ? 3 : 2);
        measure = 1'b1;
        wait (exp_q.size() == 0);
        @(negedge clk);
        measure = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset div_out", int'(div_out), 0);
        check("R6 reset mod_out", int'(mod_out), 0);
        rst = 1'b0;
        run_mode(1'b0, 1'b0, 6);
        run_mode(1'b1, 1'b0, 6);
        run_mode(1'b0, 1'b1, 6);
        run_mode(1'b1, 1'b1, 10);
        run_mode(1'b0, 1'b0, 6);
        run_mode(1'b1, 1'b1, 8);
        // reset in the middle of divide-by-1.5
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R6 mid reset div_out", int'(div_out), 0);
        check("R6 mid reset mod_out", int'(mod_out), 0);
        mod_in = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        run_mode(1'b0, 1'b0, 6);
        run_mode(1'b1, 1'b1, 6);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule